// File: doc/BRIEF.md
# Byte-Packing Data Buffer

This block is a small shift buffer of four byte lanes. It sits between a 16-bit register data port and a byte-wide serial bus engine. On the transmit side, software loads halfwords, or a single byte for the last odd byte of a message. The engine then takes bytes out, oldest first. On the receive side, the engine drops bytes into successive lanes, and software collects them two at a time through halfword reads. A byte-order input decides whether the two bytes of each halfword are swapped on their way in and out.

Transmit and receive keep separate fill levels over the same storage. Status flags report transmit readiness and underflow, receive readiness and overrun, and a trailing odd received byte. A read from an empty receive side produces a one-cycle error pulse. The surrounding controller pulses `clearBuf` when a new transfer starts. The block acts on at most one operation per clock.

Top module: `bytepack_buffer`

## Requirements
- R1: A halfword write with the transmit level above 2 leaves the buffer and the level unchanged. Otherwise the buffer shifts left by 16 bits, the halfword enters lanes 1:0, and the transmit level rises by 2.
- R2: With `byteOrder`=1 the written halfword is stored unchanged. With `byteOrder`=0 its upper and lower bytes are exchanged first.
- R3: A byte write with the transmit level above 2 is ignored. Otherwise the buffer shifts left by 8, `wrData[7:0]` enters lane 0, and the transmit level rises by 1.
- R4: Every write, accepted or not, clears `txUnderflow`. A write that leaves the transmit level above 2 clears `txReady`. A pop that leaves the level at 2 or less sets `txReady`. A pop at level 0 sets `txUnderflow` and changes nothing else.
- R5: `txByte` shows lane (transmit level − 1), so bytes leave in the order they were written, upper byte of a stored halfword first. A pop lowers the transmit level by 1.
- R6: An accepted receive push stores `rxByte` in lane (receive level), raises the level by 1 and sets `rxReady`. A push at level 4 is dropped, leaves the lanes unchanged, and sets `rxOverrun`.
- R7: `rdData` shows lanes 1:0 as {lane1, lane0} when `byteOrder`=1, and as {lane0, lane1} when it is 0. The effect of a read depends on the receive level: at level 1 it sets `singleByte` and empties the buffer; at level 2 it empties the buffer; above 2 it shifts the buffer right by 16 with zero fill and lowers the level by 2.
- R8: Every read clears `rxOverrun`. A read that leaves the receive level at 0 clears `rxReady`.
- R9: A read at receive level 0 changes no level and pulses `rdErr` for exactly the following cycle.
- R10: Reset and `clearBuf` zero all lanes, both levels and every flag.
- R11: Only the highest-priority request in a cycle takes effect. The order is `clearBuf`, `wrHalf`, `wrByte`, `rdHalf`, `txPop`, `rxPush`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clearBuf | input | 1 | Start of a new transfer: empties the buffer |
| byteOrder | input | 1 | 1: halfwords as-is, 0: bytes swapped |
| wrHalf | input | 1 | Halfword write strobe |
| wrByte | input | 1 | Byte write strobe (final odd byte) |
| wrData | input | 16 | Write data |
| rdHalf | input | 1 | Halfword read strobe |
| rdData | output | 16 | Low two lanes in the selected byte order |
| txPop | input | 1 | Engine takes the current transmit byte |
| txByte | output | 8 | Oldest pending transmit byte |
| rxPush | input | 1 | Engine delivers a received byte |
| rxByte | input | 8 | Received byte |
| txLevel | output | 3 | Pending transmit bytes |
| rxLevel | output | 3 | Held received bytes |
| txReady | output | 1 | Room for another halfword |
| txUnderflow | output | 1 | Pop seen with nothing pending |
| rxReady | output | 1 | Received data available |
| rxOverrun | output | 1 | Received byte dropped on a full buffer |
| singleByte | output | 1 | Last read returned one valid byte |
| rdErr | output | 1 | Pulse after a read of an empty buffer |

## Verification
The checker runs on every cycle. It covers the level arithmetic of accepted and ignored writes, the bounds on both levels, the clearing of underflow by writes and of overrun by reads, the empty-read pulse and its cause, and the effect of `clearBuf`. Lane contents can only be observed through a sequence of operations: byte ordering under each `byteOrder` value, oldest-first transmit order, the zero-filled right shift and the trailing-byte flag. The bench shows these by sweeping receive depths 1 to 4 and several transmit patterns under both byte orders.

// File: rtl/bytepack_pkg.sv
package bytepack_pkg;
  // Accepted operations for one cycle, issued by control to the datapath.
  typedef struct packed {
    logic clr;
    logic wrHalf;
    logic wrByte;
    logic rdHalf;
    logic popTx;
    logic pushRx;
  } bufOp_t;
endpackage

// File: rtl/bytepack_dp.sv
module bytepack_dp
  import bytepack_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  bufOp_t                            op,
  input  logic                              byteOrder,
  input  logic [2*BYTE_W-1:0]               wrData,
  input  logic [BYTE_W-1:0]                 rxByte,
  output logic [$clog2(NUM_BYTES+1)-1:0]    txCount,
  output logic [$clog2(NUM_BYTES+1)-1:0]    rxCount,
  output logic [BYTE_W-1:0]                 txByte,
  output logic [2*BYTE_W-1:0]               rdData
);
  localparam int HALF_W = 2 * BYTE_W;
  localparam int BUF_W  = NUM_BYTES * BYTE_W;
  localparam int CNT_W  = $clog2(NUM_BYTES + 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [BUF_W-1:0]  bufFlat;
  logic [HALF_W-1:0] halfIn;
  logic [HALF_W-1:0] lowHalf;
  logic              rdShift;

  // Byte order applied on the way in and on the way out.
  assign halfIn  = byteOrder ? wrData : {wrData[BYTE_W-1:0], wrData[HALF_W-1:BYTE_W]};
  assign lowHalf = bufFlat[HALF_W-1:0];
  assign rdData  = byteOrder ? lowHalf : {lowHalf[BYTE_W-1:0], lowHalf[HALF_W-1:BYTE_W]};
  assign rdShift = op.rdHalf && (rxCount > TWO);

  for (genvar g = 0; g < NUM_BYTES; g++) begin : gLane
    logic [BYTE_W-1:0] laneQ;
    logic [BYTE_W-1:0] fromHalf;
    logic [BYTE_W-1:0] fromByte;
    logic [BYTE_W-1:0] fromShift;

    if (g >= 2) begin : gHalfUp
      assign fromHalf = bufFlat[(g-2)*BYTE_W +: BYTE_W];
    end else begin : gHalfIn
      assign fromHalf = halfIn[g*BYTE_W +: BYTE_W];
    end

    if (g >= 1) begin : gByteUp
      assign fromByte = bufFlat[(g-1)*BYTE_W +: BYTE_W];
    end else begin : gByteIn
      assign fromByte = wrData[BYTE_W-1:0];
    end

    if (g + 2 < NUM_BYTES) begin : gShDown
      assign fromShift = bufFlat[(g+2)*BYTE_W +: BYTE_W];
    end else begin : gShZero
      assign fromShift = '0;
    end

    always_ff @(posedge clk) begin
      if (!rstN || op.clr) begin
        laneQ <= '0;
      end else if (op.wrHalf) begin
        laneQ <= fromHalf;
      end else if (op.wrByte) begin
        laneQ <= fromByte;
      end else if (rdShift) begin
        laneQ <= fromShift;
      end else if (op.pushRx && rxCount == CNT_W'(g)) begin
        laneQ <= rxByte;
      end
    end

    assign bufFlat[g*BYTE_W +: BYTE_W] = laneQ;
  end

  // Transmit byte: lane selected by the level minus one.
  always_comb begin
    txByte = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (txCount == CNT_W'(i + 1)) txByte = bufFlat[i*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || op.clr) begin
      txCount <= '0;
    end else if (op.wrHalf) begin
      txCount <= txCount + TWO;
    end else if (op.wrByte) begin
      txCount <= txCount + ONE;
    end else if (op.popTx) begin
      txCount <= txCount - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || op.clr) begin
      rxCount <= '0;
    end else if (op.rdHalf) begin
      if (rxCount > TWO)       rxCount <= rxCount - TWO;
      else if (rxCount != '0)  rxCount <= '0;
    end else if (op.pushRx) begin
      rxCount <= rxCount + ONE;
    end
  end
endmodule

// File: rtl/bytepack_ctrl.sv
module bytepack_ctrl
  import bytepack_pkg::*;
#(
  parameter int NUM_BYTES = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           clearBuf,
  input  logic                           wrHalf,
  input  logic                           wrByte,
  input  logic                           rdHalf,
  input  logic                           txPop,
  input  logic                           rxPush,
  input  logic [$clog2(NUM_BYTES+1)-1:0] txCount,
  input  logic [$clog2(NUM_BYTES+1)-1:0] rxCount,
  output bufOp_t                         op,
  output logic                           txReady,
  output logic                           txUnderflow,
  output logic                           rxReady,
  output logic                           rxOverrun,
  output logic                           singleByte,
  output logic                           rdErr
);
  localparam int CNT_W = $clog2(NUM_BYTES + 1);
  localparam logic [CNT_W-1:0] TX_ROOM = CNT_W'(NUM_BYTES - 2);
  localparam logic [CNT_W-1:0] FULL    = CNT_W'(NUM_BYTES);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO     = CNT_W'(2);

  logic selHalf, selByte, selRd, selPop, selPush;
  logic [CNT_W-1:0] txAfter;

  // Fixed priority: one request per cycle.
  assign selHalf = !clearBuf && wrHalf;
  assign selByte = !clearBuf && !wrHalf && wrByte;
  assign selRd   = !clearBuf && !wrHalf && !wrByte && rdHalf;
  assign selPop  = !clearBuf && !wrHalf && !wrByte && !rdHalf && txPop;
  assign selPush = !clearBuf && !wrHalf && !wrByte && !rdHalf && !txPop && rxPush;

  always_comb begin
    op        = '0;
    op.clr    = clearBuf;
    op.wrHalf = selHalf && (txCount <= TX_ROOM);
    op.wrByte = selByte && (txCount <= TX_ROOM);
    op.rdHalf = selRd;
    op.popTx  = selPop && (txCount != '0);
    op.pushRx = selPush && (rxCount < FULL);
  end

  always_comb begin
    if (op.wrHalf)      txAfter = txCount + TWO;
    else if (op.wrByte) txAfter = txCount + ONE;
    else                txAfter = txCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clearBuf) begin
      txReady     <= 1'b0;
      txUnderflow <= 1'b0;
      rxReady     <= 1'b0;
      rxOverrun   <= 1'b0;
      singleByte  <= 1'b0;
      rdErr       <= 1'b0;
    end else begin
      rdErr <= selRd && (rxCount == '0);
      if (selHalf || selByte) begin
        txUnderflow <= 1'b0;
        if (txAfter > TX_ROOM) txReady <= 1'b0;
      end
      if (selPop) begin
        if (txCount == '0)                  txUnderflow <= 1'b1;
        else if (txCount - ONE <= TX_ROOM)  txReady     <= 1'b1;
      end
      if (selRd) begin
        rxOverrun <= 1'b0;
        if (rxCount == ONE)  singleByte <= 1'b1;
        if (rxCount <= TWO)  rxReady    <= 1'b0;
      end
      if (selPush) begin
        if (rxCount < FULL) rxReady   <= 1'b1;
        else                rxOverrun <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bytepack_buffer.sv
module bytepack_buffer
  import bytepack_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           clearBuf,
  input  logic                           byteOrder,
  input  logic                           wrHalf,
  input  logic                           wrByte,
  input  logic [2*BYTE_W-1:0]            wrData,
  input  logic                           rdHalf,
  output logic [2*BYTE_W-1:0]            rdData,
  input  logic                           txPop,
  output logic [BYTE_W-1:0]              txByte,
  input  logic                           rxPush,
  input  logic [BYTE_W-1:0]              rxByte,
  output logic [$clog2(NUM_BYTES+1)-1:0] txLevel,
  output logic [$clog2(NUM_BYTES+1)-1:0] rxLevel,
  output logic                           txReady,
  output logic                           txUnderflow,
  output logic                           rxReady,
  output logic                           rxOverrun,
  output logic                           singleByte,
  output logic                           rdErr
);
  bufOp_t op;

  bytepack_ctrl #(.NUM_BYTES(NUM_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .clearBuf(clearBuf), .wrHalf(wrHalf), .wrByte(wrByte),
    .rdHalf(rdHalf), .txPop(txPop), .rxPush(rxPush), .txCount(txLevel),
    .rxCount(rxLevel), .op(op), .txReady(txReady), .txUnderflow(txUnderflow),
    .rxReady(rxReady), .rxOverrun(rxOverrun), .singleByte(singleByte), .rdErr(rdErr)
  );

  bytepack_dp #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .op(op), .byteOrder(byteOrder), .wrData(wrData),
    .rxByte(rxByte), .txCount(txLevel), .rxCount(rxLevel), .txByte(txByte),
    .rdData(rdData)
  );
endmodule

// File: rtl/bytepack_chk.sv
module bytepack_chk #(
  parameter int NUM_BYTES = 4
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           clearBuf,
  input logic                           wrHalf,
  input logic                           wrByte,
  input logic                           rdHalf,
  input logic [$clog2(NUM_BYTES+1)-1:0] txLevel,
  input logic [$clog2(NUM_BYTES+1)-1:0] rxLevel,
  input logic                           txUnderflow,
  input logic                           rxOverrun,
  input logic                           rxReady,
  input logic                           rdErr
);
  logic rdAct;
  assign rdAct = rdHalf && !clearBuf && !wrHalf && !wrByte;

  p_half_ignored_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrHalf && !clearBuf && txLevel > NUM_BYTES - 2) |=> txLevel == $past(txLevel));
  p_half_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrHalf && !clearBuf && txLevel <= NUM_BYTES - 2) |=> txLevel == $past(txLevel) + 2);
  p_byte_accept_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrByte && !wrHalf && !clearBuf && txLevel <= NUM_BYTES - 2) |=> txLevel == $past(txLevel) + 1);
  p_wr_clears_udf_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((wrHalf || wrByte) && !clearBuf) |=> !txUnderflow);
  p_tx_bound_r5: assert property (@(posedge clk) disable iff (!rstN) txLevel <= NUM_BYTES);
  p_rx_bound_r6: assert property (@(posedge clk) disable iff (!rstN) rxLevel <= NUM_BYTES);
  p_rd_clears_ovr_r8: assert property (@(posedge clk) disable iff (!rstN) rdAct |=> !rxOverrun);
  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdAct && rxLevel == 0) |=> (rdErr && rxLevel == 0));
  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rstN) rdErr |-> $past(rdHalf));
  p_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    clearBuf |=> (txLevel == 0 && rxLevel == 0 && !rxReady && !rdErr));
endmodule

bind bytepack_buffer bytepack_chk #(.NUM_BYTES(NUM_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .clearBuf(clearBuf), .wrHalf(wrHalf), .wrByte(wrByte),
  .rdHalf(rdHalf), .txLevel(txLevel), .rxLevel(rxLevel), .txUnderflow(txUnderflow),
  .rxOverrun(rxOverrun), .rxReady(rxReady), .rdErr(rdErr)
);

// File: tb/bytepack_buffer_tb.sv
module bytepack_buffer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clearBuf = 0, byteOrder = 0, wrHalf = 0, wrByte = 0, rdHalf = 0, txPop = 0, rxPush = 0;
  logic [15:0] wrData = '0;
  logic [7:0]  rxByte = '0;
  logic [15:0] rdData;
  logic [7:0]  txByte;
  logic [2:0]  txLevel, rxLevel;
  logic txReady, txUnderflow, rxReady, rxOverrun, singleByte, rdErr;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bytepack_buffer u_dut (
    .clk(clk), .rstN(rstN), .clearBuf(clearBuf), .byteOrder(byteOrder), .wrHalf(wrHalf),
    .wrByte(wrByte), .wrData(wrData), .rdHalf(rdHalf), .rdData(rdData), .txPop(txPop),
    .txByte(txByte), .rxPush(rxPush), .rxByte(rxByte), .txLevel(txLevel), .rxLevel(rxLevel),
    .txReady(txReady), .txUnderflow(txUnderflow), .rxReady(rxReady), .rxOverrun(rxOverrun),
    .singleByte(singleByte), .rdErr(rdErr)
  );

  function automatic logic [15:0] sw(input logic [15:0] h);
    return {h[7:0], h[15:8]};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    clearBuf = 0; wrHalf = 0; wrByte = 0; rdHalf = 0; txPop = 0; rxPush = 0;
  endtask

  task automatic doClr();              clearBuf = 1; tick(); endtask
  task automatic doWrH(input logic [15:0] d); wrData = d; wrHalf = 1; tick(); endtask
  task automatic doWrB(input logic [7:0] d);  wrData = {8'h00, d}; wrByte = 1; tick(); endtask
  task automatic doPop();              txPop = 1; tick(); endtask
  task automatic doPush(input logic [7:0] d); rxByte = d; rxPush = 1; tick(); endtask
  task automatic doRd();               rdHalf = 1; tick(); endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] h1, h2, s1, s2, h3;
    logic [31:0] w;
    logic [7:0]  m [4];
    int cnt;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "txLevel", txLevel, 0);
    chk("R10", "rxLevel", rxLevel, 0);
    chk("R10", "flags", {txReady, txUnderflow, rxReady, rxOverrun, singleByte, rdErr}, 0);
    chk("R10", "rdData", rdData, 0);

    // R1 R2 R5 R4: transmit sweep over both byte orders
    for (int o = 0; o < 2; o++) begin
      for (int k = 0; k < 4; k++) begin
        byteOrder = o[0];
        h1 = 16'h1234 + 16'(k) * 16'h2357;
        h2 = 16'hA0C1 ^ (16'(k) * 16'h1111);
        s1 = o[0] ? h1 : sw(h1);
        s2 = o[0] ? h2 : sw(h2);
        w  = {s1, s2};
        doClr();
        doWrH(h1);
        chk("R1", "txLevel after first half", txLevel, 2);
        doWrH(h2);
        chk("R1", "txLevel after second half", txLevel, 4);
        chk("R4", "txReady cleared when level above 2", txReady, 0);
        for (int j = 0; j < 4; j++) begin
          chk("R5", "txByte order", txByte, w[8*(3-j) +: 8]);
          if (j == 0) chk("R2", "first byte reflects byte order", txByte, o[0] ? h1[15:8] : h1[7:0]);
          doPop();
          chk("R5", "txLevel after pop", txLevel, 3 - j);
        end
        chk("R4", "txReady after draining", txReady, 1);
        doPop();
        chk("R4", "underflow on empty pop", txUnderflow, 1);
        chk("R4", "level unchanged on empty pop", txLevel, 0);
        doWrH(h1);
        chk("R4", "write clears underflow", txUnderflow, 0);
      end
    end

    // R1 ignored third halfword; R3 byte write and ignored byte
    byteOrder = 1;
    h1 = 16'h5A6B; h2 = 16'h7C8D; h3 = 16'hEEEE;
    doClr();
    doWrH(h1); doWrH(h2); doWrH(h3);
    chk("R1", "txLevel after ignored write", txLevel, 4);
    w = {h1, h2};
    for (int j = 0; j < 4; j++) begin
      chk("R1", "contents unchanged by ignored write", txByte, w[8*(3-j) +: 8]);
      doPop();
    end
    doClr();
    doWrH(h1);
    doWrB(8'h3C);
    chk("R3", "txLevel after byte write", txLevel, 3);
    doWrB(8'h99);
    chk("R3", "byte write at level 3 ignored", txLevel, 3);
    chk("R3", "first byte", txByte, h1[15:8]); doPop();
    chk("R3", "second byte", txByte, h1[7:0]); doPop();
    chk("R3", "odd byte last", txByte, 8'h3C); doPop();
    chk("R3", "level zero", txLevel, 0);

    // R6 R7 R8: receive sweep over depths 1..4 and both byte orders
    for (int o = 0; o < 2; o++) begin
      for (int n = 1; n <= 4; n++) begin
        byteOrder = o[0];
        doClr();
        for (int i = 0; i < 4; i++) m[i] = 8'h00;
        for (int i = 0; i < n; i++) begin
          m[i] = 8'(8'h41 + 8'(16 * n) + 8'(i) * 8'h13);
          doPush(m[i]);
        end
        chk("R6", "rxLevel after pushes", rxLevel, n);
        chk("R6", "rxReady set", rxReady, 1);
        cnt = n;
        while (cnt > 0) begin
          chk("R7", "rdData", rdData, o[0] ? {m[1], m[0]} : {m[0], m[1]});
          doRd();
          if (cnt == 1) begin
            chk("R7", "singleByte on odd tail", singleByte, 1);
            cnt = 0;
          end else if (cnt == 2) begin
            chk("R7", "no singleByte on even", singleByte, 0);
            cnt = 0;
          end else begin
            m[0] = m[2]; m[1] = m[3]; m[2] = 8'h00; m[3] = 8'h00;
            cnt = cnt - 2;
          end
          chk("R7", "rxLevel after read", rxLevel, cnt);
          chk("R8", "rxReady follows level", rxReady, cnt != 0);
        end
      end
    end

    // R6 R8 overrun
    byteOrder = 1;
    doClr();
    for (int i = 0; i < 4; i++) doPush(8'(8'h10 + i));
    doPush(8'hFF);
    chk("R6", "overrun flag", rxOverrun, 1);
    chk("R6", "level stays full", rxLevel, 4);
    chk("R6", "dropped byte left lanes intact", rdData, 16'h1110);
    doRd();
    chk("R8", "read clears overrun", rxOverrun, 0);
    chk("R6", "upper lanes intact", rdData, 16'h1312);

    // R9 empty read
    doRd();
    chk("R7", "level zero", rxLevel, 0);
    doRd();
    chk("R9", "rdErr pulse", rdErr, 1);
    chk("R9", "rxLevel unchanged", rxLevel, 0);
    chk("R9", "txLevel unchanged", txLevel, 0);
    tick();
    chk("R9", "rdErr one cycle", rdErr, 0);

    // R11 priority
    doClr();
    doPush(8'h21); doPush(8'h22);
    wrData = 16'h4455; wrHalf = 1; rdHalf = 1; rxPush = 1; rxByte = 8'h77; tick();
    chk("R11", "write wins over read", txLevel, 2);
    chk("R11", "read and push suppressed", rxLevel, 2);
    rdHalf = 1; txPop = 1; tick();
    chk("R11", "read wins over pop", txLevel, 2);
    chk("R11", "read acted", rxLevel, 0);
    clearBuf = 1; wrHalf = 1; wrData = 16'h1111; tick();
    chk("R11", "clear wins over write", txLevel, 0);

    // R10 clear of loaded state
    doWrH(16'hBEEF);
    doPush(8'h01);
    doPush(8'h02);
    doClr();
    chk("R10", "levels cleared", {txLevel, rxLevel}, 0);
    chk("R10", "flags cleared", {txReady, txUnderflow, rxReady, rxOverrun, singleByte, rdErr}, 0);
    chk("R10", "lanes cleared", rdData, 0);
    chk("R10", "tx byte cleared", txByte, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule